// File: doc/BRIEF.md
# Event-Driven PWM Waveform Generator

This block drives one PWM output from an internal counter. The counter runs in one of three modes: it counts up and wraps, it counts down and reloads, or it counts up and back down. As it runs it raises events. These are the counter at zero, the counter at its top value, and matches against two compare values. One compare value belongs to the odd channel and one to the even channel. Each channel match comes in a rising-direction form and a falling-direction form. Every event has its own two-bit action, which sets what it does to the output. When several events fall on the same count, a fixed priority for each mode picks the one action that applies. This makes 0% and 100% duty fall out without special cases.

The top value and both compare values are held in shadow registers. New settings therefore take effect only at a period boundary, and a period in progress is never cut short. While the enable input is low, the counter rests at zero and the output keeps its level. In that state new settings are taken at once. The output level is registered, so it follows the count that produced it by one clock. A direction flag shows which way the counter is moving.

Top module: `pwm_event_gen`

## Requirements
- R1: After reset the output is low and the direction flag is 1 (up). While enable is low, no event acts on the output, so configured actions produce no pulses.
- R2: Action codes are 0 = keep, 1 = drive low, 2 = drive high, 3 = invert the output. A toggle action on the zero event alone gives a 50% duty over two periods.
- R3: With mode 0 (mode 3 behaves the same) the counter runs 0,1,…,P and then wraps to 0, so a period lasts P+1 clocks. With the zero event set high and the odd rising match set low, compare value C gives C of every P+1 clocks high, and any C above P gives a constant high.
- R4: In mode 0 the priority from highest to lowest is: top event, odd rising match, even rising match, zero event. A compare value of 0 therefore gives 0% duty.
- R5: With mode 2 the counter runs 0 up to P and back down to 1, so a period lasts 2·P clocks. The direction flag is 1 on counts 0 to P−1 and 0 from P on the way down to 1.
- R6: In mode 2, rising matches fire only while the direction flag is 1 and falling matches only while it is 0. With the odd rising match set low and the odd falling match set high, compare value C gives 2·C high clocks of every 2·P.
- R7: With mode 1 the counter loads P, counts down to 0 and reloads, so a period lasts P+1 clocks and the direction flag reads 0. The priority is: zero event, odd falling match, even falling match, top event.
- R8: In mode 2 the priority is: zero event, top event, odd-channel match, even-channel match.
- R9: An event whose action is keep does not mask a lower-priority event that fires on the same count.
- R10: A new top value or compare value written while the counter runs takes effect only when the period ends. In modes 0 and 2 that is the return to 0, and in mode 1 it is the reload at 0.
- R11: While enable is low the counter is held at 0, the direction flag reads 1, and the output keeps its last level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the counter and apply events |
| mode_i | input | 2 | Counter mode: 0 up, 1 down, 2 up-down, 3 as up |
| period_i | input | CNT_W | Top count P (shadowed) |
| cmp_odd_i | input | CNT_W | Odd-channel compare value (shadowed) |
| cmp_even_i | input | CNT_W | Even-channel compare value (shadowed) |
| act_zero_i | input | 2 | Action on the zero event |
| act_top_i | input | 2 | Action on the top event |
| act_odd_up_i | input | 2 | Action on the odd rising match |
| act_odd_dn_i | input | 2 | Action on the odd falling match |
| act_even_up_i | input | 2 | Action on the even rising match |
| act_even_dn_i | input | 2 | Action on the even falling match |
| pwm_o | output | 1 | Registered PWM level |
| dir_up_o | output | 1 | 1 while counting up, 0 while counting down |

## Verification
Several rules are checked on every cycle by the embedded properties. The count never passes the active top value. Up mode wraps after the top count, and up-down mode reverses there. Down mode always reports down. The shadow values change only at a boundary. A disabled block holds its output, and the highest-priority event wins in up and down modes. Duty ratios, the full priority orders between compare channels, the keep action not masking a lower event, and the exact period lengths before and after a mid-period update can only be shown by the bench. It runs the counter in each mode with chosen action sets and counts high clocks and edge spacing.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

   typedef enum logic [1:0] {
      ACT_KEEP = 2'd0,
      ACT_LOW  = 2'd1,
      ACT_HIGH = 2'd2,
      ACT_FLIP = 2'd3
   } pwm_act_e;

   typedef enum logic [1:0] {
      CM_UP   = 2'd0,
      CM_DOWN = 2'd1,
      CM_UPDN = 2'd2,
      CM_RSVD = 2'd3
   } cnt_mode_e;

   // event bits, base index order used by the resolver
   localparam int NUM_EVT   = 6;
   localparam int EV_ZERO   = 0;
   localparam int EV_TOP    = 1;
   localparam int EV_ODD_UP = 2;
   localparam int EV_ODD_DN = 3;
   localparam int EV_EVN_UP = 4;
   localparam int EV_EVN_DN = 5;

   localparam int NUM_CH = 2;   // channel 0 = odd, channel 1 = even

endpackage

// File: rtl/pwm_evt_counter.sv
module pwm_evt_counter
   import pwm_evt_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  cnt_mode_e        mode_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] cmp_odd_i,
   input  logic [CNT_W-1:0] cmp_even_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] cmpo_o,
   output logic [CNT_W-1:0] cmpe_o,
   output logic             dir_up_o
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             dir_q, dir_nxt;
   logic             load;

   always_comb begin
      cnt_nxt = ZERO;
      dir_nxt = 1'b1;
      case (mode_i)
         CM_DOWN: begin
            cnt_nxt = (cnt_q == ZERO) ? period_i : cnt_q - ONE;
            dir_nxt = 1'b0;
         end
         CM_UPDN: begin
            if (cnt_q == ZERO)
               cnt_nxt = (per_o == ZERO) ? ZERO : ONE;
            else if (dir_q && (cnt_q < per_o))
               cnt_nxt = cnt_q + ONE;
            else
               cnt_nxt = cnt_q - ONE;
            if (cnt_nxt == ZERO)
               dir_nxt = 1'b1;
            else if (cnt_nxt >= per_o)
               dir_nxt = 1'b0;
            else
               dir_nxt = (cnt_q == ZERO) ? 1'b1 : dir_q;
         end
         default: begin
            cnt_nxt = (cnt_q >= per_o) ? ZERO : cnt_q + ONE;
            dir_nxt = 1'b1;
         end
      endcase
   end

   // boundary at which shadowed settings become active
   assign load = !enable_i ||
                 ((mode_i == CM_DOWN) ? (cnt_q == ZERO) : (cnt_nxt == ZERO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         dir_q <= 1'b1;
      end else if (!enable_i) begin
         cnt_q <= ZERO;
         dir_q <= 1'b1;
      end else begin
         cnt_q <= cnt_nxt;
         dir_q <= dir_nxt;
      end
   end

   generate
      if (SHADOW_EN) begin : g_shadow
         logic [CNT_W-1:0] per_q, cmpo_q, cmpe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               per_q  <= ZERO;
               cmpo_q <= ZERO;
               cmpe_q <= ZERO;
            end else if (load) begin
               per_q  <= period_i;
               cmpo_q <= cmp_odd_i;
               cmpe_q <= cmp_even_i;
            end
         end
         assign per_o  = per_q;
         assign cmpo_o = cmpo_q;
         assign cmpe_o = cmpe_q;

         AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= per_q);  // R3
         AST_SHADOW_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(enable_i) && !$stable(per_q)) |-> (cnt_q == ZERO || cnt_q == per_q));  // R10
      end else begin : g_direct
         logic unused_load;
         assign unused_load = load;
         assign per_o  = period_i;
         assign cmpo_o = cmp_odd_i;
         assign cmpe_o = cmp_even_i;
      end
   endgenerate

   assign cnt_o    = cnt_q;
   assign dir_up_o = dir_q;

   AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && mode_i == CM_UP && cnt_q == per_o) |=> (cnt_q == ZERO));  // R3
   AST_UD_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && mode_i == CM_UPDN && per_o != ZERO && cnt_q == per_o) |-> !dir_q);  // R5
   AST_DN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && $past(enable_i) && mode_i == CM_DOWN && $past(mode_i) == CM_DOWN) |-> !dir_q);  // R7
   AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (cnt_q == ZERO && dir_q));  // R11

endmodule

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
   import pwm_evt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  cnt_mode_e        mode_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] cmpo_i,
   input  logic [CNT_W-1:0] cmpe_i,
   input  logic             dir_up_i,
   output logic [NUM_EVT-1:0] evt_o
);

   logic going_up;
   logic [CNT_W-1:0] cmp_val [NUM_CH];
   logic [NUM_CH-1:0] hit_up, hit_dn;

   always_comb begin
      case (mode_i)
         CM_DOWN: going_up = 1'b0;
         CM_UPDN: going_up = dir_up_i;
         default: going_up = 1'b1;
      endcase
   end

   assign cmp_val[0] = cmpo_i;
   assign cmp_val[1] = cmpe_i;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic match;
         assign match      = (cnt_i == cmp_val[ch]);
         assign hit_up[ch] = match && going_up;
         assign hit_dn[ch] = match && !going_up;
      end
   endgenerate

   always_comb begin
      evt_o            = '0;
      evt_o[EV_ZERO]   = (cnt_i == '0);
      evt_o[EV_TOP]    = (cnt_i == per_i);
      evt_o[EV_ODD_UP] = hit_up[0];
      evt_o[EV_ODD_DN] = hit_dn[0];
      evt_o[EV_EVN_UP] = hit_up[1];
      evt_o[EV_EVN_DN] = hit_dn[1];
   end

endmodule

// File: rtl/pwm_evt_resolve.sv
module pwm_evt_resolve
   import pwm_evt_pkg::*;
#(
   parameter bit INIT_LEVEL = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable_i,
   input  cnt_mode_e          mode_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  pwm_act_e           act_i [NUM_EVT],
   output logic               pwm_o
);

   // priority order per mode, highest first, as base event indices
   localparam int ORD_UP   [NUM_EVT] = '{EV_TOP, EV_ODD_UP, EV_EVN_UP, EV_ZERO, EV_ODD_DN, EV_EVN_DN};
   localparam int ORD_DOWN [NUM_EVT] = '{EV_ZERO, EV_ODD_DN, EV_EVN_DN, EV_TOP, EV_ODD_UP, EV_EVN_UP};
   localparam int ORD_UPDN [NUM_EVT] = '{EV_ZERO, EV_TOP, EV_ODD_UP, EV_ODD_DN, EV_EVN_UP, EV_EVN_DN};

   pwm_act_e sel;
   logic     lvl_q, lvl_nxt;

   always_comb begin
      int ord [NUM_EVT];
      case (mode_i)
         CM_DOWN: ord = ORD_DOWN;
         CM_UPDN: ord = ORD_UPDN;
         default: ord = ORD_UP;
      endcase
      sel = ACT_KEEP;
      // walk lowest to highest so the highest live, non-keep action remains
      for (int i = NUM_EVT - 1; i >= 0; i--) begin
         if (evt_i[ord[i]] && act_i[ord[i]] != ACT_KEEP)
            sel = act_i[ord[i]];
      end
   end

   always_comb begin
      case (sel)
         ACT_LOW:  lvl_nxt = 1'b0;
         ACT_HIGH: lvl_nxt = 1'b1;
         ACT_FLIP: lvl_nxt = ~lvl_q;
         default:  lvl_nxt = lvl_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_q <= INIT_LEVEL;
      else if (enable_i)
         lvl_q <= lvl_nxt;
   end

   assign pwm_o = lvl_q;

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> $stable(pwm_o));  // R11
   AST_UP_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && mode_i == CM_UP && evt_i[EV_TOP] && act_i[EV_TOP] == ACT_LOW) |=> !pwm_o);  // R4
   AST_DN_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && mode_i == CM_DOWN && evt_i[EV_ZERO] && act_i[EV_ZERO] == ACT_HIGH) |=> pwm_o);  // R7
   AST_UD_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && mode_i == CM_UPDN && evt_i[EV_ZERO] && act_i[EV_ZERO] == ACT_LOW) |=> !pwm_o);  // R8

endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
   import pwm_evt_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit SHADOW_EN  = 1'b1,
   parameter bit INIT_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic [1:0]       mode_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] cmp_odd_i,
   input  logic [CNT_W-1:0] cmp_even_i,
   input  logic [1:0]       act_zero_i,
   input  logic [1:0]       act_top_i,
   input  logic [1:0]       act_odd_up_i,
   input  logic [1:0]       act_odd_dn_i,
   input  logic [1:0]       act_even_up_i,
   input  logic [1:0]       act_even_dn_i,
   output logic             pwm_o,
   output logic             dir_up_o
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_event_gen: CNT_W must lie in 2..32");
      end
   endgenerate

   cnt_mode_e          mode;
   logic [CNT_W-1:0]   cnt, per, cmpo, cmpe;
   logic               dir_up;
   logic [NUM_EVT-1:0] evt;
   pwm_act_e           acts [NUM_EVT];

   assign mode            = cnt_mode_e'(mode_i);
   assign acts[EV_ZERO]   = pwm_act_e'(act_zero_i);
   assign acts[EV_TOP]    = pwm_act_e'(act_top_i);
   assign acts[EV_ODD_UP] = pwm_act_e'(act_odd_up_i);
   assign acts[EV_ODD_DN] = pwm_act_e'(act_odd_dn_i);
   assign acts[EV_EVN_UP] = pwm_act_e'(act_even_up_i);
   assign acts[EV_EVN_DN] = pwm_act_e'(act_even_dn_i);

   pwm_evt_counter #(.CNT_W(CNT_W), .SHADOW_EN(SHADOW_EN)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (enable_i),
      .mode_i    (mode),
      .period_i  (period_i),
      .cmp_odd_i (cmp_odd_i),
      .cmp_even_i(cmp_even_i),
      .cnt_o     (cnt),
      .per_o     (per),
      .cmpo_o    (cmpo),
      .cmpe_o    (cmpe),
      .dir_up_o  (dir_up)
   );

   pwm_evt_detect #(.CNT_W(CNT_W)) u_det (
      .mode_i  (mode),
      .cnt_i   (cnt),
      .per_i   (per),
      .cmpo_i  (cmpo),
      .cmpe_i  (cmpe),
      .dir_up_i(dir_up),
      .evt_o   (evt)
   );

   pwm_evt_resolve #(.INIT_LEVEL(INIT_LEVEL)) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable_i(enable_i),
      .mode_i  (mode),
      .evt_i   (evt),
      .act_i   (acts),
      .pwm_o   (pwm_o)
   );

   assign dir_up_o = dir_up;

endmodule

// File: tb/tb_pwm_event_gen.sv
module tb_pwm_event_gen;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable_i = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic [W-1:0] period_i = '0, cmp_odd_i = '0, cmp_even_i = '0;
   logic [1:0] act_zero_i = 2'd0, act_top_i = 2'd0, act_odd_up_i = 2'd0;
   logic [1:0] act_odd_dn_i = 2'd0, act_even_up_i = 2'd0, act_even_dn_i = 2'd0;
   logic pwm_o, dir_up_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int    exp_q [$];
   string tag_q [$];
   int    got_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_event_gen #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
      .period_i(period_i), .cmp_odd_i(cmp_odd_i), .cmp_even_i(cmp_even_i),
      .act_zero_i(act_zero_i), .act_top_i(act_top_i),
      .act_odd_up_i(act_odd_up_i), .act_odd_dn_i(act_odd_dn_i),
      .act_even_up_i(act_even_up_i), .act_even_dn_i(act_even_dn_i),
      .pwm_o(pwm_o), .dir_up_o(dir_up_o)
   );

   // scoreboard monitor
   always @(negedge clk) begin
      while (exp_q.size() > 0 && got_q.size() > 0) begin
         int e, g;
         string t;
         e = exp_q.pop_front();
         g = got_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (e != g) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", t, g, e);
         end
      end
   end

   task automatic expect_val(input string t, input int v);
      exp_q.push_back(v);
      tag_q.push_back(t);
   endtask

   task automatic observe(input int v);
      got_q.push_back(v);
   endtask

   task automatic cfg(input int md, input int p, input int co, input int ce,
                      input int az, input int at, input int aou, input int aod,
                      input int aeu, input int aed);
      @(negedge clk);
      enable_i = 1'b0;
      mode_i = md[1:0]; period_i = p[W-1:0];
      cmp_odd_i = co[W-1:0]; cmp_even_i = ce[W-1:0];
      act_zero_i = az[1:0]; act_top_i = at[1:0];
      act_odd_up_i = aou[1:0]; act_odd_dn_i = aod[1:0];
      act_even_up_i = aeu[1:0]; act_even_dn_i = aed[1:0];
      repeat (2) @(negedge clk);
      enable_i = 1'b1;
      repeat (24) @(negedge clk);
   endtask

   task automatic measure(input int n, output int hi, output int up);
      hi = 0; up = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_o) hi++;
         if (dir_up_o) up++;
      end
   endtask

   task automatic edge_gap(output int k);
      logic prev;
      prev = pwm_o;
      k = 0;
      while (pwm_o == prev && k < 200) begin
         @(negedge clk);
         k++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi, up, k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      expect_val("R1 reset pwm", 0); observe(int'(pwm_o));
      expect_val("R1 reset dir", 1); observe(int'(dir_up_o));
      // R1 no pulses while disabled
      act_zero_i = 2'd2; period_i = 8'd4;
      measure(12, hi, up);
      expect_val("R1 idle pwm high count", 0); observe(hi);

      // R3/R4 up mode duty, zero high, odd rising low
      for (int c = 0; c <= 7; c++) begin
         cfg(0, 4, c, 9, 2, 0, 1, 0, 0, 0);
         measure(10, hi, up);
         expect_val($sformatf("R3 R4 up duty C=%0d", c), (c > 4) ? 10 : 2*c); observe(hi);
         if (c == 2) begin
            expect_val("R3 up dir count", 10); observe(up);
         end
      end
      // R4 odd rising beats even rising
      cfg(0, 4, 2, 2, 2, 0, 1, 0, 2, 0);
      measure(10, hi, up);
      expect_val("R4 odd over even", 4); observe(hi);
      // R4 top event beats odd rising
      cfg(0, 4, 4, 9, 1, 2, 1, 0, 0, 0);
      measure(10, hi, up);
      expect_val("R4 top over odd", 2); observe(hi);
      // R9 keep action does not mask zero event
      cfg(0, 4, 0, 2, 2, 0, 0, 0, 1, 0);
      measure(10, hi, up);
      expect_val("R9 keep no mask", 4); observe(hi);
      // R2 toggle on zero
      cfg(0, 4, 9, 9, 3, 0, 0, 0, 0, 0);
      measure(10, hi, up);
      expect_val("R2 toggle duty", 5); observe(hi);
      // R2 mode 3 treated as up
      cfg(3, 4, 3, 9, 2, 0, 1, 0, 0, 0);
      measure(10, hi, up);
      expect_val("R3 mode3 as up", 6); observe(hi);

      // R5/R6 up-down duty
      for (int c = 0; c <= 4; c++) begin
         cfg(2, 4, c, 9, 0, 0, 1, 2, 0, 0);
         measure(16, hi, up);
         expect_val($sformatf("R6 updown duty C=%0d", c), 4*c); observe(hi);
         if (c == 1) begin
            expect_val("R5 updown dir count", 8); observe(up);
         end
      end
      // R8 zero beats odd
      cfg(2, 4, 0, 9, 2, 0, 1, 0, 0, 0);
      measure(16, hi, up);
      expect_val("R8 zero over odd", 16); observe(hi);
      // R8 top beats odd falling
      cfg(2, 4, 4, 9, 0, 1, 0, 2, 0, 0);
      measure(16, hi, up);
      expect_val("R8 top over odd", 0); observe(hi);
      // R8 odd beats even
      cfg(2, 4, 1, 1, 0, 0, 1, 2, 2, 1);
      measure(16, hi, up);
      expect_val("R8 odd over even", 4); observe(hi);

      // R7 down mode
      cfg(1, 4, 2, 9, 2, 0, 0, 1, 0, 0);
      measure(10, hi, up);
      expect_val("R7 down duty C=2", 6); observe(hi);
      expect_val("R7 down dir count", 0); observe(up);
      cfg(1, 4, 0, 9, 2, 0, 0, 1, 0, 0);
      measure(10, hi, up);
      expect_val("R7 zero over odd", 10); observe(hi);
      cfg(1, 4, 4, 9, 1, 1, 0, 2, 0, 0);
      measure(10, hi, up);
      expect_val("R7 odd over top", 8); observe(hi);
      cfg(1, 4, 3, 3, 0, 0, 0, 1, 0, 2);
      measure(10, hi, up);
      expect_val("R7 odd over even", 0); observe(hi);

      // R10 mid-period update of the top value
      cfg(0, 9, 20, 20, 3, 0, 0, 0, 0, 0);
      edge_gap(k);
      begin
         logic prev;
         prev = pwm_o;
         k = 0;
         while (pwm_o == prev && k < 200) begin
            @(negedge clk);
            k++;
            if (k == 3) period_i = 8'd2;
         end
      end
      expect_val("R10 old period kept", 10); observe(k);
      edge_gap(k);
      expect_val("R10 new period", 3); observe(k);

      // R11 disabled holds level and reports up
      mode_i = 2'd1;
      @(negedge clk);
      enable_i = 1'b0;
      @(negedge clk);
      begin
         logic held;
         int changes;
         held = pwm_o;
         changes = 0;
         up = 0;
         repeat (20) begin
            @(negedge clk);
            if (pwm_o != held) changes++;
            if (dir_up_o) up++;
         end
         expect_val("R11 disabled changes", 0); observe(changes);
         expect_val("R11 disabled dir", 20); observe(up);
      end

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0 || got_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard unmatched actual %0d expected %0d", got_q.size(), exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule